// File: doc/BRIEF.md
# Transmit Head Write-Back Engine

This block reports transmit completions for a bank of transmit queues by writing the queue's 32-bit head pointer to a host memory location that software chooses. It replaces the usual practice of setting a done bit in the descriptor itself. Each queue has two address registers. The lower one carries a per-queue enable in its least significant bit. Together the two registers form a 4-byte aligned 64-bit target address.

A completion event carries a queue index, the descriptor's report-status flag and an indication that the descriptor's data has reached the packet buffer. The event is taken only once that upload indication is present. The block then does one of three things:
- With the queue enabled and report-status set, it queues a memory write request of the target address and the queue's current head value.
- With the queue disabled and report-status set, it raises a same-cycle flag asking for a legacy descriptor write-back.
- With report-status clear, it does nothing.

Write requests wait in a small FIFO and leave through a valid/ready port in arrival order.

Top module: `txhead_wb_engine`

## Requirements
- R1: There are NUM_Q (default 64) queues. `reg_wr_q` selects the queue. `reg_wr_hi`=0 writes that queue's low address register and `reg_wr_hi`=1 writes its high address register.
- R2: In the low register, bit 0 is the queue's enable. Bits 31:2 become target address bits 31:2. Bit 1 is ignored, and target address bits 1:0 are always zero.
- R3: The high register supplies target address bits 63:32.
- R4: An event is accepted when `cmp_valid`, `cmp_upload_done` and `cmp_ready` are all high. An accepted event with `cmp_rs`=1 on an enabled queue makes `wr_valid` high in the next cycle, with the target address on `wr_addr`.
- R5: An event with `cmp_upload_done`=0 has no effect: no write request is made and `desc_wb_req` stays low.
- R6: `wr_data` equals the queue's head value in `head_flat[q*32 +: 32]` as sampled in the acceptance cycle.
- R7: An event on an enabled queue never raises `desc_wb_req`.
- R8: An accepted event with `cmp_rs`=1 on a disabled queue raises `desc_wb_req` combinationally in the acceptance cycle and makes no write request. An event with `cmp_rs`=0 raises neither.
- R9: Write requests leave in arrival order. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady. `cmp_ready` is low while the FIFO holds FIFO_DEPTH (default 4) entries, and events in that state are not accepted.
- R10: After reset all address registers are zero, so every queue is disabled, `wr_valid` is low and `cmp_ready` is high.
- R11: When a register write and an accepted event target the same queue in the same cycle, the event uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_q | input | 6 | Queue index of the register write |
| reg_wr_hi | input | 1 | 1 selects the high address register, 0 the low one |
| reg_wr_data | input | 32 | Register write data |
| cmp_valid | input | 1 | Completion event present |
| cmp_q | input | 6 | Queue of the completion event |
| cmp_rs | input | 1 | Report-status flag of the completed descriptor |
| cmp_upload_done | input | 1 | Descriptor data upload to packet buffer finished |
| cmp_ready | output | 1 | Event can be accepted (FIFO not full) |
| head_flat | input | 2048 | Concatenated 32-bit head values, queue q at bits q*32+31:q*32 |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write request taken |
| wr_addr | output | 64 | Write-back target address |
| wr_data | output | 32 | Head value to write |
| desc_wb_req | output | 1 | Legacy descriptor write-back needed for this event |

## Verification
A register update and a completion event can land on the same queue in the same clock. The bench provokes this by enabling a queue and then, in a single cycle, clearing its enable and moving its address while an event with report-status arrives for it. The check passes when no legacy flag appears, the queued request carries the old address, and a later event on that queue sees the new disabled state. Back-pressure is also combined with queue filling: stalled requests must stay stable, events at full must be refused, and the drained order must match the order of arrival.

// File: rtl/txhwb_pkg.sv
package txhwb_pkg;
  localparam int ADDR_W = 64;
  localparam int HEAD_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [HEAD_W-1:0] data;
  } wb_req_t;
endpackage

// File: rtl/txhwb_regfile.sv
module txhwb_regfile #(
  parameter int NUM_Q = 64,
  localparam int Q_W = $clog2(NUM_Q)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [Q_W-1:0] wr_q,
  input  logic          wr_hi,
  input  logic [31:0]   wr_data,
  input  logic [Q_W-1:0] rd_q,
  output logic          rd_en,
  output logic [63:0]   rd_addr
);
  logic [29:0] lo_addr [NUM_Q];
  logic        lo_en   [NUM_Q];
  logic [31:0] hi_addr [NUM_Q];

  // one clock enable per register
  generate
    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
      logic lo_ce, hi_ce;
      assign lo_ce = wr_en && (wr_q == Q_W'(g)) && !wr_hi;
      assign hi_ce = wr_en && (wr_q == Q_W'(g)) &&  wr_hi;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_addr[g] <= '0;
          lo_en[g]   <= 1'b0;
          hi_addr[g] <= '0;
        end else begin
          if (lo_ce) begin
            lo_addr[g] <= wr_data[31:2];
            lo_en[g]   <= wr_data[0];
          end
          if (hi_ce) hi_addr[g] <= wr_data;
        end
      end
    end
  endgenerate

  // reads see pre-write contents
  always_comb begin
    rd_en   = lo_en[rd_q];
    rd_addr = {hi_addr[rd_q], lo_addr[rd_q], 2'b00};
  end
endmodule

// File: rtl/txhwb_event.sv
module txhwb_event #(
  parameter int NUM_Q = 64,
  localparam int Q_W = $clog2(NUM_Q)
) (
  input  logic                    cmp_valid,
  input  logic [Q_W-1:0]          cmp_q,
  input  logic                    cmp_rs,
  input  logic                    cmp_upload_done,
  input  logic                    fifo_full,
  input  logic [NUM_Q*32-1:0]     head_flat,
  input  logic                    q_en,
  input  logic [63:0]             q_addr,
  output logic                    push,
  output txhwb_pkg::wb_req_t      push_req,
  output logic                    desc_req
);
  logic accept;

  always_comb begin
    accept        = cmp_valid && cmp_upload_done && !fifo_full;
    push          = accept && cmp_rs && q_en;
    desc_req      = accept && cmp_rs && !q_en;
    push_req.addr = q_addr;
    push_req.data = head_flat[cmp_q*32 +: 32];
  end
endmodule

// File: rtl/txhwb_fifo.sv
module txhwb_fifo #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  txhwb_pkg::wb_req_t push_req,
  input  logic               pop,
  output logic               full,
  output logic               not_empty,
  output txhwb_pkg::wb_req_t head_req
);
  txhwb_pkg::wb_req_t mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_req;
  end

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign head_req  = mem[rp_q];
endmodule

// File: rtl/txhead_wb_engine.sv
module txhead_wb_engine #(
  parameter int NUM_Q      = 64,
  parameter int FIFO_DEPTH = 4,
  localparam int Q_W = $clog2(NUM_Q)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [Q_W-1:0]      reg_wr_q,
  input  logic                reg_wr_hi,
  input  logic [31:0]         reg_wr_data,
  input  logic                cmp_valid,
  input  logic [Q_W-1:0]      cmp_q,
  input  logic                cmp_rs,
  input  logic                cmp_upload_done,
  output logic                cmp_ready,
  input  logic [NUM_Q*32-1:0] head_flat,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [63:0]         wr_addr,
  output logic [31:0]         wr_data,
  output logic                desc_wb_req
);
  logic               q_en, push, full, not_empty;
  logic [63:0]        q_addr;
  txhwb_pkg::wb_req_t push_req, head_req;

  txhwb_regfile #(.NUM_Q(NUM_Q)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_q(reg_wr_q), .wr_hi(reg_wr_hi), .wr_data(reg_wr_data),
    .rd_q(cmp_q), .rd_en(q_en), .rd_addr(q_addr)
  );

  txhwb_event #(.NUM_Q(NUM_Q)) u_evt (
    .cmp_valid(cmp_valid), .cmp_q(cmp_q), .cmp_rs(cmp_rs),
    .cmp_upload_done(cmp_upload_done), .fifo_full(full),
    .head_flat(head_flat), .q_en(q_en), .q_addr(q_addr),
    .push(push), .push_req(push_req), .desc_req(desc_wb_req)
  );

  txhwb_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_req(push_req), .pop(wr_valid && wr_ready),
    .full(full), .not_empty(not_empty), .head_req(head_req)
  );

  assign cmp_ready = !full;
  assign wr_valid  = not_empty;
  assign wr_addr   = head_req.addr;
  assign wr_data   = head_req.data;
endmodule

// File: rtl/txhwb_chk.sv
module txhwb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_valid,
  input logic        cmp_rs,
  input logic        cmp_upload_done,
  input logic        cmp_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [63:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        desc_wb_req
);
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[1:0] == 2'b00);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_upload_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(cmp_valid && cmp_upload_done && cmp_rs && cmp_ready));

  assert_desc_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb_req |-> (cmp_valid && cmp_upload_done && cmp_rs && cmp_ready));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb_req |=> !$rose(wr_valid));
endmodule

bind txhead_wb_engine txhwb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_rs(cmp_rs),
  .cmp_upload_done(cmp_upload_done), .cmp_ready(cmp_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .desc_wb_req(desc_wb_req)
);

// File: tb/txhead_wb_engine_tb.sv
module txhead_wb_engine_tb;
  localparam int NQ = 64;
  localparam int DEPTH = 4;

  logic clk, rst_n;
  logic reg_wr_en, reg_wr_hi;
  logic [5:0] reg_wr_q, cmp_q;
  logic [31:0] reg_wr_data;
  logic cmp_valid, cmp_rs, cmp_upload_done, cmp_ready;
  logic [NQ*32-1:0] head_flat;
  logic wr_valid, wr_ready, desc_wb_req;
  logic [63:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, fails = 0;
  int phase = 0;

  txhead_wb_engine u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] lo_val(int q);
    return 32'h8000_0000 | (q << 8) | ((q % 3 == 0) ? 32'h2 : 32'h0) | ((q % 2 == 0) ? 32'h1 : 32'h0);
  endfunction
  function automatic logic [31:0] hi_val(int q);
    return 32'h4000_0000 + q * 32'h11;
  endfunction
  function automatic logic [63:0] exp_addr(int q);
    return {hi_val(q), lo_val(q) & 32'hFFFF_FFFC};
  endfunction
  function automatic logic [31:0] head_of(int q);
    return 32'hC000_0000 + q * 7 + phase * 32'h100;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_heads();
    for (int q = 0; q < NQ; q++) head_flat[q*32 +: 32] = head_of(q);
  endtask

  task automatic reg_write(input int q, input logic hi, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_q = 6'(q); reg_wr_hi = hi; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  // drive one event with wr_ready high and check its outcome
  task automatic one_event(input int q, input logic rs, input logic up,
                           input logic exp_desc, input logic exp_wr, input string req);
    @(negedge clk);
    cmp_valid = 1; cmp_q = 6'(q); cmp_rs = rs; cmp_upload_done = up;
    #1 chk({req, " desc flag"}, 64'(desc_wb_req), 64'(exp_desc));
    @(negedge clk);
    cmp_valid = 0;
    chk({req, " wr_valid"}, 64'(wr_valid), 64'(exp_wr));
    if (exp_wr) begin
      chk({req, " addr"}, wr_addr, exp_addr(q));
      chk({req, " data R6"}, 64'(wr_data), 64'(head_of(q)));
    end
    @(negedge clk);
    chk({req, " drained"}, 64'(wr_valid), 64'd0);
  endtask

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_wr_q = 0; reg_wr_hi = 0; reg_wr_data = 0;
    cmp_valid = 0; cmp_q = 0; cmp_rs = 0; cmp_upload_done = 0; wr_ready = 1;
    load_heads();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 wr_valid", 64'(wr_valid), 64'd0);
    chk("R10 cmp_ready", 64'(cmp_ready), 64'd1);
    one_event(5, 1, 1, 1, 0, "R10 disabled after reset");

    // R1 R2 R3: program every queue
    for (int q = 0; q < NQ; q++) begin
      reg_write(q, 0, lo_val(q));
      reg_write(q, 1, hi_val(q));
    end

    // R4 R7 R8: sweep all queues, both rs values
    for (int q = 0; q < NQ; q++) begin
      phase = q; load_heads();
      one_event(q, 1, 1, (q % 2 != 0), (q % 2 == 0), "R4 R7 R8 rs=1");
      one_event(q, 0, 1, 0, 0, "R8 rs=0");
    end

    // R5: upload not done, enabled and disabled queues
    one_event(4, 1, 0, 0, 0, "R5 enabled");
    one_event(7, 1, 0, 0, 0, "R5 disabled");

    // R9: fill FIFO under stall, check full, refusal, order
    wr_ready = 0;
    phase = 99; load_heads();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      cmp_valid = 1; cmp_q = 6'(2 * i + 10); cmp_rs = 1; cmp_upload_done = 1;
    end
    @(negedge clk);
    chk("R9 full cmp_ready", 64'(cmp_ready), 64'd0);
    cmp_q = 6'd40; // enabled queue, must be refused
    @(negedge clk);
    cmp_valid = 0;
    chk("R9 stall addr", wr_addr, exp_addr(10));
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_ready = 1;
      chk("R9 order addr", wr_addr, exp_addr(2 * i + 10));
      chk("R9 order data", 64'(wr_data), 64'(head_of(2 * i + 10)));
      @(negedge clk);
      wr_ready = 0;
    end
    @(negedge clk);
    chk("R9 refused event absent", 64'(wr_valid), 64'd0);
    wr_ready = 1;

    // R11: same-cycle register write and event on queue 2
    phase = 7; load_heads();
    @(negedge clk);
    reg_wr_en = 1; reg_wr_q = 6'd2; reg_wr_hi = 0; reg_wr_data = 32'h1234_5670;
    cmp_valid = 1; cmp_q = 6'd2; cmp_rs = 1; cmp_upload_done = 1;
    #1 chk("R11 desc flag old enable", 64'(desc_wb_req), 64'd0);
    @(negedge clk);
    reg_wr_en = 0; cmp_valid = 0;
    chk("R11 wr_valid", 64'(wr_valid), 64'd1);
    chk("R11 old addr", wr_addr, exp_addr(2));
    @(negedge clk);
    @(negedge clk);
    cmp_valid = 1; cmp_q = 6'd2;
    #1 chk("R11 new state disabled", 64'(desc_wb_req), 64'd1);
    @(negedge clk);
    cmp_valid = 0;
    chk("R11 no write after disable", 64'(wr_valid), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule